// File: doc/BRIEF.md
# Two-Bank Fetch Collapser

This block sits at the end of a wide instruction fetch stage. In one cycle it takes the two instruction lines read from an instruction cache that is split into two interleaved banks. The fetch addresses for those lines come from a branch target buffer that makes more than one prediction per cycle. Because of the bank mapping, the earlier line in program order can come out of either bank. An interchange stage therefore puts the two lines back into predicted sequential order. A collapsing stage then removes every instruction whose valid bit the predictions have cleared. This happens, for example, after a predicted-taken branch inside a line or before a branch target that lies in the middle of a line.

Each valid instruction moves to the output slot whose index equals the number of valid instructions ahead of it. The survivors therefore form a gap-free, order-preserving run, reported together with a count. The result is held in a single output register with a valid/ready handshake.

Top module: `fetch_collapser`

## Requirements
- R1: While reset is asserted and in the cycle after it, `out_valid` is 0 and `out_count` is 0.
- R2: With `b1_first` = 0 the bank 0 line is earlier in program order: sequence positions 0..3 are bank 0 lanes 0..3 and positions 4..7 are bank 1 lanes 0..3. Lane k of a line is bits [32k+31:32k], and mask bit k belongs to lane k.
- R3: With `b1_first` = 1 the bank 1 line comes first (positions 0..3) and the bank 0 line follows (positions 4..7). Each mask travels with its own bank's line.
- R4: Instructions whose mask bit is 0 are removed. The valid ones appear in output slots 0, 1, 2, ... in sequence order, where slot j is bits [32j+31:32j] of `out_insns`. For lines ABCD and EFGH with D, F and H invalid, the output is A B C E G.
- R5: `out_count` equals the number of set mask bits of the accepted request (0 to 8).
- R6: Every output slot at or above `out_count` is zero while `out_valid` is 1.
- R7: A request accepted at a clock edge (`in_valid` and `in_ready` both 1) appears on the outputs with `out_valid` = 1 right after that edge.
- R8: While `out_valid` is 1 and `out_ready` is 0, the outputs hold their values and `in_ready` is 0. A request offered during that time is not taken.
- R9: `in_ready` is 1 whenever `out_valid` is 0 or `out_ready` is 1, so a new request can be accepted in every cycle.
- R10: A request with all mask bits clear is still delivered, with `out_count` = 0 and all slots zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| bank0_line | input | 128 | Four instructions read from bank 0 |
| bank1_line | input | 128 | Four instructions read from bank 1 |
| bank0_mask | input | 4 | Predicted-valid bits for bank 0 lanes |
| bank1_mask | input | 4 | Predicted-valid bits for bank 1 lanes |
| b1_first | input | 1 | 1: bank 1 line precedes bank 0 line |
| out_valid | output | 1 | Packed result present |
| out_ready | input | 1 | Consumer takes the result |
| out_insns | output | 256 | Up to eight packed instructions, slot 0 lowest |
| out_count | output | 4 | Number of valid packed instructions |

## Verification
The collapse is driven with a fully valid pair, which shows that bank ordering alone is right. The case from the requirements, with holes in both lines, shows that survivors keep their order across the line boundary. The same case is repeated with the lines placed in opposite banks and the swap select set, which separates a correct interchange from one that ignores the select. A lone survivor in the last lane, a lone survivor in the first lane and an empty mask check the boundaries of the prefix count and the zeroing of the tail. Stalling the consumer and then streaming back-to-back requests separates correct holding from dropped or duplicated results.

// File: rtl/fc_pkg.sv
package fc_pkg;
    typedef enum logic {
        ORDER_B0_FIRST = 1'b0,
        ORDER_B1_FIRST = 1'b1
    } fc_order_e;
endpackage

// File: rtl/fc_interchange.sv
module fc_interchange
    import fc_pkg::*;
#(
    parameter int INSN_W = 32,
    parameter int LANES  = 4
) (
    input  logic [LANES*INSN_W-1:0]   bank0_line,
    input  logic [LANES*INSN_W-1:0]   bank1_line,
    input  logic [LANES-1:0]          bank0_mask,
    input  logic [LANES-1:0]          bank1_mask,
    input  fc_order_e                 order,
    output logic [2*LANES*INSN_W-1:0] seq_line,
    output logic [2*LANES-1:0]        seq_mask
);
    // lower half of the sequence is the earlier line
    always_comb begin
        if (order == ORDER_B1_FIRST) begin
            seq_line = {bank0_line, bank1_line};
            seq_mask = {bank0_mask, bank1_mask};
        end else begin
            seq_line = {bank1_line, bank0_line};
            seq_mask = {bank1_mask, bank0_mask};
        end
    end
endmodule

// File: rtl/fc_compactor.sv
module fc_compactor #(
    parameter int INSN_W = 32,
    parameter int SLOTS  = 8,
    localparam int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic [SLOTS*INSN_W-1:0] seq_line,
    input  logic [SLOTS-1:0]        seq_mask,
    output logic [SLOTS*INSN_W-1:0] packed_line,
    output logic [CNT_W-1:0]        packed_count
);
    logic [CNT_W-1:0]  dest_idx [SLOTS];
    logic [INSN_W-1:0] slot_word [SLOTS];

    // prefix count: destination of each entry = valid entries ahead of it
    always_comb begin
        logic [CNT_W-1:0] run;
        run = '0;
        for (int i = 0; i < SLOTS; i++) begin
            dest_idx[i] = run;
            run = run + CNT_W'(seq_mask[i]);
        end
        packed_count = run;
    end

    for (genvar j = 0; j < SLOTS; j++) begin : g_slot
        always_comb begin
            slot_word[j] = '0;
            for (int i = 0; i < SLOTS; i++) begin
                if (seq_mask[i] && (dest_idx[i] == CNT_W'(j))) begin
                    slot_word[j] = seq_line[i*INSN_W +: INSN_W];
                end
            end
        end
        assign packed_line[j*INSN_W +: INSN_W] = slot_word[j];
    end
endmodule

// File: rtl/fetch_collapser.sv
module fetch_collapser
    import fc_pkg::*;
#(
    parameter int INSN_W = 32,
    parameter int LANES  = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  in_valid,
    output logic                                  in_ready,
    input  logic [LANES*INSN_W-1:0]               bank0_line,
    input  logic [LANES*INSN_W-1:0]               bank1_line,
    input  logic [LANES-1:0]                      bank0_mask,
    input  logic [LANES-1:0]                      bank1_mask,
    input  logic                                  b1_first,
    output logic                                  out_valid,
    input  logic                                  out_ready,
    output logic [2*LANES*INSN_W-1:0]             out_insns,
    output logic [$clog2(2*LANES+1)-1:0]          out_count
);
    localparam int SLOTS = 2 * LANES;
    localparam int CNT_W = $clog2(SLOTS + 1);

    typedef struct packed {
        logic                    vld;
        logic [CNT_W-1:0]        cnt;
        logic [SLOTS*INSN_W-1:0] data;
    } hold_t;

    hold_t state_d, state_q;

    logic [SLOTS*INSN_W-1:0] seq_line;
    logic [SLOTS-1:0]        seq_mask;
    logic [SLOTS*INSN_W-1:0] packed_line;
    logic [CNT_W-1:0]        packed_count;
    logic                    accept;

    fc_interchange #(.INSN_W(INSN_W), .LANES(LANES)) u_xchg (
        .bank0_line (bank0_line),
        .bank1_line (bank1_line),
        .bank0_mask (bank0_mask),
        .bank1_mask (bank1_mask),
        .order      (fc_order_e'(b1_first)),
        .seq_line   (seq_line),
        .seq_mask   (seq_mask)
    );

    fc_compactor #(.INSN_W(INSN_W), .SLOTS(SLOTS)) u_pack (
        .seq_line     (seq_line),
        .seq_mask     (seq_mask),
        .packed_line  (packed_line),
        .packed_count (packed_count)
    );

    assign in_ready = !state_q.vld || out_ready;
    assign accept   = in_valid && in_ready;

    always_comb begin
        state_d = state_q;
        if (accept) begin
            state_d.vld  = 1'b1;
            state_d.cnt  = packed_count;
            state_d.data = packed_line;
        end else if (out_ready) begin
            state_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.vld;
    assign out_count = state_q.cnt;
    assign out_insns = state_q.data;
endmodule

// File: rtl/fc_checker.sv
module fc_checker #(
    parameter int INSN_W = 32,
    parameter int LANES  = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          in_valid,
    input logic                          in_ready,
    input logic                          out_valid,
    input logic                          out_ready,
    input logic [2*LANES*INSN_W-1:0]     out_insns,
    input logic [$clog2(2*LANES+1)-1:0]  out_count
);
    localparam int SLOTS = 2 * LANES;

    logic tail_dirty;
    always_comb begin
        tail_dirty = 1'b0;
        for (int j = 0; j < SLOTS; j++) begin
            if (j >= int'(out_count) && out_insns[j*INSN_W +: INSN_W] != '0) begin
                tail_dirty = 1'b1;
            end
        end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_count) <= SLOTS)); // R5

    AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !tail_dirty); // R6

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid); // R7

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_insns) && $stable(out_count))); // R8

    AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready); // R8

    AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid || out_ready) |-> in_ready); // R9
endmodule

bind fetch_collapser fc_checker #(.INSN_W(INSN_W), .LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_insns (out_insns),
    .out_count (out_count)
);

// File: tb/fetch_collapser_tb.sv
module fetch_collapser_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] bank0_line = '0;
    logic [127:0] bank1_line = '0;
    logic [3:0]   bank0_mask = '0;
    logic [3:0]   bank1_mask = '0;
    logic         b1_first = 1'b0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [255:0] out_insns;
    logic [3:0]   out_count;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    fetch_collapser u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .bank0_line(bank0_line), .bank1_line(bank1_line),
        .bank0_mask(bank0_mask), .bank1_mask(bank1_mask), .b1_first(b1_first),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_insns(out_insns), .out_count(out_count)
    );

    task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] mk_line(input logic [31:0] base);
        return {base + 32'd3, base + 32'd2, base + 32'd1, base};
    endfunction

    // reference: walk the two lines in program order, append the valid ones
    function automatic void ref_pack(input logic [127:0] l0, input logic [127:0] l1,
                                     input logic [3:0] m0, input logic [3:0] m1,
                                     input logic sw, output logic [255:0] d,
                                     output logic [3:0] c);
        logic [127:0] first_l, second_l;
        logic [3:0]   first_m, second_m;
        int k;
        first_l  = sw ? l1 : l0;
        second_l = sw ? l0 : l1;
        first_m  = sw ? m1 : m0;
        second_m = sw ? m0 : m1;
        d = '0;
        k = 0;
        for (int i = 0; i < 4; i++) if (first_m[i]) begin
            d[k*32 +: 32] = first_l[i*32 +: 32]; k++;
        end
        for (int i = 0; i < 4; i++) if (second_m[i]) begin
            d[k*32 +: 32] = second_l[i*32 +: 32]; k++;
        end
        c = 4'(k);
    endfunction

    task automatic drive(input logic [127:0] l0, input logic [127:0] l1,
                         input logic [3:0] m0, input logic [3:0] m1, input logic sw);
        bank0_line = l0; bank1_line = l1;
        bank0_mask = m0; bank1_mask = m1;
        b1_first = sw;
        in_valid = 1'b1;
    endtask

    task automatic run_case(input string tag, input logic [127:0] l0, input logic [127:0] l1,
                            input logic [3:0] m0, input logic [3:0] m1, input logic sw);
        logic [255:0] ed;
        logic [3:0]   ec;
        ref_pack(l0, l1, m0, m1, sw, ed, ec);
        @(negedge clk);
        out_ready = 1'b1;
        drive(l0, l1, m0, m1, sw);
        #1;
        check({tag, " R9 in_ready"}, 256'(in_ready), 256'd1);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " R7 out_valid"}, 256'(out_valid), 256'd1);
        check({tag, " R4/R6 data"}, out_insns, ed);
        check({tag, " R5 count"}, 256'(out_count), 256'(ec));
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 valid in reset", 256'(out_valid), 256'd0);
        check("R1 count in reset", 256'(out_count), 256'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", 256'(out_valid), 256'd0);
        check("R9 ready when idle", 256'(in_ready), 256'd1);
    endtask

    task automatic t_all_valid_b0_first();
        run_case("R2 all valid", mk_line(32'h1000_0000), mk_line(32'h2000_0000), 4'hF, 4'hF, 1'b0);
        check("R2 slot4 is bank1 lane0", 256'(out_insns[159:128]), 256'h2000_0000);
    endtask

    task automatic t_example();
        // A..D in bank0, E..H in bank1, D F H invalid -> A B C E G
        run_case("R4 example", mk_line(32'hA0), mk_line(32'hE0), 4'b0111, 4'b0101, 1'b0);
        check("R4 example literal", out_insns[159:0],
              {96'd0, 32'hE2, 32'hE0, 32'hA2, 32'hA1, 32'hA0} >> 0 & {96'd0, {160{1'b1}}});
    endtask

    task automatic t_example_swapped();
        // same program order, lines returned from opposite banks
        run_case("R3 swapped", mk_line(32'hE0), mk_line(32'hA0), 4'b0101, 4'b0111, 1'b1);
        check("R3 swapped literal", out_insns[159:0],
              {32'hE2, 32'hE0, 32'hA2, 32'hA1, 32'hA0});
        check("R6 slot5 zero", 256'(out_insns[191:160]), 256'd0);
    endtask

    task automatic t_edges();
        run_case("R5 last lane only", mk_line(32'h30), mk_line(32'h40), 4'b0000, 4'b1000, 1'b0);
        check("R5 last lane moved to slot0", 256'(out_insns[31:0]), 256'h43);
        run_case("R3 first lane only", mk_line(32'h50), mk_line(32'h60), 4'b0000, 4'b0001, 1'b1);
        check("R3 bank1 lane0 in slot0", 256'(out_insns[31:0]), 256'h60);
        run_case("R10 empty", mk_line(32'h70), mk_line(32'h80), 4'b0000, 4'b0000, 1'b1);
        check("R10 all zero", out_insns, 256'd0);
    endtask

    task automatic t_backpressure();
        logic [255:0] ed_a, ed_b;
        logic [3:0]   ec_a, ec_b;
        ref_pack(mk_line(32'h900), mk_line(32'h910), 4'b1010, 4'b0110, 1'b0, ed_a, ec_a);
        ref_pack(mk_line(32'h920), mk_line(32'h930), 4'b1111, 4'b0001, 1'b1, ed_b, ec_b);
        @(negedge clk);
        out_ready = 1'b0;
        drive(mk_line(32'h900), mk_line(32'h910), 4'b1010, 4'b0110, 1'b0);
        @(posedge clk);
        @(negedge clk);
        drive(mk_line(32'h920), mk_line(32'h930), 4'b1111, 4'b0001, 1'b1);
        #1;
        check("R8 ready low in stall", 256'(in_ready), 256'd0);
        @(posedge clk);
        @(negedge clk);
        check("R8 valid held", 256'(out_valid), 256'd1);
        check("R8 data held", out_insns, ed_a);
        check("R8 count held", 256'(out_count), 256'(ec_a));
        out_ready = 1'b1;
        #1;
        check("R9 ready with consumer", 256'(in_ready), 256'd1);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check("R8 next taken after stall", out_insns, ed_b);
        check("R8 next count", 256'(out_count), 256'(ec_b));
        @(posedge clk);
        @(negedge clk);
        check("R9 drained", 256'(out_valid), 256'd0);
    endtask

    task automatic t_stream();
        logic [255:0] ed;
        logic [3:0]   ec;
        @(negedge clk);
        out_ready = 1'b1;
        for (int n = 0; n < 6; n++) begin
            drive(mk_line(32'h100 * n), mk_line(32'h100 * n + 32'h80),
                  4'(n * 5 + 3), 4'(15 - n * 2), n[0]);
            ref_pack(bank0_line, bank1_line, bank0_mask, bank1_mask, b1_first, ed, ec);
            @(posedge clk);
            @(negedge clk);
            check("R9 stream data", out_insns, ed);
            check("R7 stream count", 256'(out_count), 256'(ec));
        end
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        t_reset();
        t_all_valid_b0_first();
        t_example();
        t_example_swapped();
        t_edges();
        t_backpressure();
        t_stream();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule